// File: doc/BRIEF.md
# Transmit Power-Amplifier Ramp Sequencer

This block drives the stage enables of a burst transmitter's power amplifier. A transmit request is accepted only while burst operation is selected. The block then waits for the frequency synthesizer to report lock. After lock it waits a coded turn-on delay, then turns amplifier stages on one at a time, starting at the lowest level, until it reaches a target level chosen by a 2-bit power code. At that level it holds and raises a done flag.

An end-of-burst pulse makes the block turn the stages off again, one by one. It spreads a coded ramp-down time evenly over the stages that are on, then returns to idle with every stage off. If end-of-burst arrives early, during the wait for lock, the delay or the climb, the block winds down from whatever level it has reached.

All time settings are counted in clock cycles, using a parameter that gives the number of cycles per microsecond. The outputs are a level code and a matching thermometer of stage enables. Analog power control and envelope shaping are outside this block.

Top module: `pa_ramp_seq`

## Requirements
- R1: While reset is asserted and right after it, `stage_lvl` is 0, `stage_en` is all zeros and `ramp_done` is 0.
- R2: With `burst_mode` low, `tx_req` is ignored in idle. `stage_lvl` stays 0 even while `pll_lock` is high.
- R3: After a request has been accepted, no stage turns on until `pll_lock` has been sampled high.
- R4: The turn-on delay code picks D = 0, 50, 100 or 150 µs times CYC_PER_US cycles (code 00, 01, 10, 11). Level 1 appears D clock edges after the edge that samples the lock.
- R5: Level k (k ≥ 1) appears UP_STEP_CYC·(k−1) edges after level 1, up to a target of power code + 1 (00→1, 01→2, 10→3, 11→4). The level never changes by more than 1 per cycle and never exceeds the target.
- R6: `ramp_done` is high exactly while the level is held at the target.
- R7: `burst_end` sampled during hold starts the ramp-down. The ramp-down time code picks T = 5, 10, 20 or 30 µs times CYC_PER_US cycles (code 00, 01, 10, 11). With L stages on, the level drops by one every S = max(1, floor(T/L)) edges, the first drop coming S edges after the sampling edge, and the block ends in idle at level 0.
- R8: `burst_end` sampled during the lock wait or the turn-on delay returns the block to idle at level 0 with no ramp. Sampled during the climb at level L, it starts the ramp-down from L with step S as in R7.
- R9: The power, delay and ramp-down codes are captured on the edge that accepts `tx_req`. Later changes to these codes do not affect the burst in progress.
- R10: `stage_en` is a thermometer code: bit i is 1 exactly when `stage_lvl` > i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_mode | input | 1 | Burst transmit operation selected |
| tx_req | input | 1 | Transmit request, sampled in idle |
| pll_lock | input | 1 | Synthesizer locked for transmission |
| burst_end | input | 1 | End of burst or abort |
| pwr_code | input | 2 | Target power code |
| on_dly_code | input | 2 | Turn-on delay code |
| down_code | input | 2 | Ramp-down time code |
| stage_lvl | output | LVL_W | Number of amplifier stages on |
| stage_en | output | NUM_STAGES | Thermometer of stage enables |
| ramp_done | output | 1 | Holding at the target level |

## Verification
The assertions check the following on every cycle: each level change is a single step, the level stays at or below the captured target, the thermometer matches the level, the done flag implies the target level, and the done flag falls only after an end-of-burst. The exact delay, climb and ramp-down timing cannot be seen by a per-cycle property. Neither can the split of the ramp-down time by the active stage count, the handling of each abort point, the capture of the codes or the rejection of requests outside burst operation. The directed scenarios show these, comparing the level against a timeline computed from the codes.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCKWAIT,
    ST_DELAY,
    ST_UP,
    ST_HOLD,
    ST_DOWN
  } ramp_st_e;

  // turn-on delay in microseconds for each 2-bit code
  function automatic int unsigned on_delay_us(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 50;
      2'd2:    return 100;
      default: return 150;
    endcase
  endfunction

  // total ramp-down time in microseconds for each 2-bit code
  function automatic int unsigned ramp_down_us(input logic [1:0] code);
    case (code)
      2'd0:    return 5;
      2'd1:    return 10;
      2'd2:    return 20;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/pa_ramp_cfg.sv
module pa_ramp_cfg
  import pa_ramp_pkg::*;
#(
  parameter int CYC_PER_US = 2,
  parameter int CNT_W      = 10,
  parameter int LVL_W      = 3
) (
  input  logic [1:0]       pwr_code,
  input  logic [1:0]       dly_code,
  input  logic [1:0]       dn_code,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic [LVL_W-1:0] tgt_lvl,
  output logic [CNT_W-1:0] dly_cyc,
  output logic [CNT_W-1:0] dn_step
);

  logic [CNT_W-1:0] dn_total;
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] quot;

  always_comb begin
    tgt_lvl  = LVL_W'(pwr_code) + LVL_W'(1);
    dly_cyc  = CNT_W'(on_delay_us(dly_code) * CYC_PER_US);
    dn_total = CNT_W'(ramp_down_us(dn_code) * CYC_PER_US);
    divisor  = (cur_lvl == '0) ? CNT_W'(1) : CNT_W'(cur_lvl);
    quot     = dn_total / divisor;
    dn_step  = (quot == '0) ? CNT_W'(1) : quot;
  end

endmodule

// File: rtl/pa_ramp_timer.sv
module pa_ramp_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pa_ramp_thermo.sv
module pa_ramp_thermo #(
  parameter int NUM_STAGES = 4,
  parameter int LVL_W      = 3
) (
  input  logic [LVL_W-1:0]      lvl,
  output logic [NUM_STAGES-1:0] en
);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    assign en[i] = (lvl > LVL_W'(i));
  end

endmodule

// File: rtl/pa_ramp_seq.sv
module pa_ramp_seq
  import pa_ramp_pkg::*;
#(
  parameter int  CYC_PER_US  = 2,
  parameter int  NUM_STAGES  = 4,
  parameter int  UP_STEP_CYC = 4,
  localparam int LVL_W       = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  burst_mode,
  input  logic                  tx_req,
  input  logic                  pll_lock,
  input  logic                  burst_end,
  input  logic [1:0]            pwr_code,
  input  logic [1:0]            on_dly_code,
  input  logic [1:0]            down_code,
  output logic [LVL_W-1:0]      stage_lvl,
  output logic [NUM_STAGES-1:0] stage_en,
  output logic                  ramp_done
);

  localparam int MAX_CYC = 150 * CYC_PER_US;
  localparam int TOP_CYC = (MAX_CYC > UP_STEP_CYC) ? MAX_CYC : UP_STEP_CYC;
  localparam int CNT_W   = $clog2(TOP_CYC + 1);

  ramp_st_e         st, st_n;
  logic [LVL_W-1:0] lvl, lvl_n;
  logic [1:0]       cap_pwr, cap_dly, cap_dn;
  logic             cap_en;
  logic [CNT_W-1:0] step_q, step_n;

  logic [LVL_W-1:0] tgt_lvl;
  logic [CNT_W-1:0] dly_cyc;
  logic [CNT_W-1:0] dn_step;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  pa_ramp_cfg #(
    .CYC_PER_US(CYC_PER_US),
    .CNT_W     (CNT_W),
    .LVL_W     (LVL_W)
  ) u_cfg (
    .pwr_code(cap_pwr),
    .dly_code(cap_dly),
    .dn_code (cap_dn),
    .cur_lvl (lvl),
    .tgt_lvl (tgt_lvl),
    .dly_cyc (dly_cyc),
    .dn_step (dn_step)
  );

  pa_ramp_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  pa_ramp_thermo #(
    .NUM_STAGES(NUM_STAGES),
    .LVL_W     (LVL_W)
  ) u_thermo (
    .lvl(lvl),
    .en (stage_en)
  );

  // next-state logic
  always_comb begin
    st_n     = st;
    lvl_n    = lvl;
    step_n   = step_q;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: begin
        if (burst_mode && tx_req) begin
          cap_en = 1'b1;
          st_n   = ST_LOCKWAIT;
        end
      end
      ST_LOCKWAIT: begin
        if (burst_end) begin
          st_n = ST_IDLE;
        end else if (pll_lock) begin
          if (dly_cyc == '0) begin
            lvl_n    = LVL_W'(1);
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(UP_STEP_CYC - 1);
            st_n     = (tgt_lvl == LVL_W'(1)) ? ST_HOLD : ST_UP;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = dly_cyc - CNT_W'(1);
            st_n     = ST_DELAY;
          end
        end
      end
      ST_DELAY: begin
        if (burst_end) begin
          st_n = ST_IDLE;
        end else if (tmr_zero) begin
          lvl_n    = LVL_W'(1);
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(UP_STEP_CYC - 1);
          st_n     = (tgt_lvl == LVL_W'(1)) ? ST_HOLD : ST_UP;
        end
      end
      ST_UP: begin
        if (burst_end) begin
          step_n   = dn_step;
          tmr_load = 1'b1;
          tmr_val  = dn_step - CNT_W'(1);
          st_n     = ST_DOWN;
        end else if (tmr_zero) begin
          lvl_n    = lvl + LVL_W'(1);
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(UP_STEP_CYC - 1);
          if (lvl + LVL_W'(1) == tgt_lvl) st_n = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (burst_end) begin
          step_n   = dn_step;
          tmr_load = 1'b1;
          tmr_val  = dn_step - CNT_W'(1);
          st_n     = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (tmr_zero) begin
          lvl_n    = lvl - LVL_W'(1);
          tmr_load = 1'b1;
          tmr_val  = step_q - CNT_W'(1);
          if (lvl == LVL_W'(1)) st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lvl     <= '0;
      step_q  <= CNT_W'(1);
      cap_pwr <= '0;
      cap_dly <= '0;
      cap_dn  <= '0;
    end else begin
      st     <= st_n;
      lvl    <= lvl_n;
      step_q <= step_n;
      if (cap_en) begin
        cap_pwr <= pwr_code;
        cap_dly <= on_dly_code;
        cap_dn  <= down_code;
      end
    end
  end

  assign stage_lvl = lvl;
  assign ramp_done = (st == ST_HOLD);

endmodule

// File: rtl/pa_ramp_seq_chk.sv
module pa_ramp_seq_chk #(
  parameter int NUM_STAGES = 4,
  parameter int LVL_W      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  burst_end,
  input logic [LVL_W-1:0]      stage_lvl,
  input logic [NUM_STAGES-1:0] stage_en,
  input logic                  ramp_done,
  input logic [LVL_W-1:0]      tgt_lvl
);

  // R5: one stage at a time
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_lvl == $past(stage_lvl)) ||
    (stage_lvl == $past(stage_lvl) + LVL_W'(1)) ||
    (stage_lvl == $past(stage_lvl) - LVL_W'(1)));

  // R5: never above the captured target
  assert_level_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stage_lvl <= tgt_lvl);

  // R6: done only at the target
  assert_done_at_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> (stage_lvl == tgt_lvl));

  // R7: leaving hold needs an end-of-burst
  assert_done_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_done) |-> $past(burst_end));

  // R10: thermometer matches the level
  assert_thermo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(stage_en) == int'(stage_lvl)) &&
    ((NUM_STAGES'(stage_en + NUM_STAGES'(1)) & stage_en) == '0));

endmodule

bind pa_ramp_seq pa_ramp_seq_chk #(
  .NUM_STAGES(NUM_STAGES),
  .LVL_W     (LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .burst_end(burst_end),
  .stage_lvl(stage_lvl),
  .stage_en (stage_en),
  .ramp_done(ramp_done),
  .tgt_lvl  (tgt_lvl)
);

// File: tb/tb_pa_ramp_seq.sv
module tb_pa_ramp_seq;

  localparam int CPU   = 2;
  localparam int NST   = 4;
  localparam int USTEP = 4;
  localparam int LW    = $clog2(NST + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_mode = 1'b0, tx_req = 1'b0, pll_lock = 1'b0, burst_end = 1'b0;
  logic [1:0] pwr_code = '0, on_dly_code = '0, down_code = '0;
  logic [LW-1:0]  stage_lvl;
  logic [NST-1:0] stage_en;
  logic           ramp_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pa_ramp_seq #(.CYC_PER_US(CPU), .NUM_STAGES(NST), .UP_STEP_CYC(USTEP)) dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .tx_req(tx_req),
    .pll_lock(pll_lock), .burst_end(burst_end), .pwr_code(pwr_code),
    .on_dly_code(on_dly_code), .down_code(down_code),
    .stage_lvl(stage_lvl), .stage_en(stage_en), .ramp_done(ramp_done)
  );

  function automatic int dly_cyc(input int c);
    int us[4] = '{0, 50, 100, 150};
    return us[c] * CPU;
  endfunction

  function automatic int dn_cyc(input int c);
    int us[4] = '{5, 10, 20, 30};
    return us[c] * CPU;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(input int exp_lvl, input int exp_done, input string req);
    chk(int'(stage_lvl), exp_lvl, req);
    chk(int'(ramp_done), exp_done, {req, " done"});
    chk(int'(stage_en), (1 << exp_lvl) - 1, "R10 thermometer");
  endtask

  task automatic start_req(input int p, input int d, input int n);
    @(negedge clk);
    burst_mode = 1'b1;
    pwr_code = 2'(p); on_dly_code = 2'(d); down_code = 2'(n);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  // raise lock at the current negedge, follow ncyc edges of the climb
  task automatic up_phase(input int p, input int d, input int ncyc);
    int dd = dly_cyc(d);
    int tg = p + 1;
    pll_lock = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      int e;
      @(negedge clk);
      if (t < dd) e = 0;
      else begin
        e = (t - dd) / USTEP + 1;
        if (e > tg) e = tg;
      end
      chk_state(e, (e == tg) ? 1 : 0, "R4 R5 R6 climb");
    end
  endtask

  task automatic down_phase(input int n, input int l, input string req);
    int s = dn_cyc(n) / l;
    if (s < 1) s = 1;
    burst_end = 1'b1;
    for (int t = 0; t <= l * s + 2; t++) begin
      int e;
      @(negedge clk);
      burst_end = 1'b0;
      e = l - t / s;
      if (e < 0) e = 0;
      chk_state(e, 0, req);
    end
    pll_lock = 1'b0;
  endtask

  task automatic run_full(input int p, input int d, input int n);
    start_req(p, d, n);
    up_phase(p, d, dly_cyc(d) + p * USTEP + 4);
    down_phase(n, p + 1, "R7 ramp-down");
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk_state(0, 0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_state(0, 0, "R1 after reset");
  endtask

  task automatic test_nonburst;
    @(negedge clk);
    burst_mode = 1'b0; tx_req = 1'b1; pll_lock = 1'b1; pwr_code = 2'd3;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      chk_state(0, 0, "R2 ignored outside burst");
    end
    tx_req = 1'b0; pll_lock = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_nolock_capture;
    start_req(2, 0, 1);
    pwr_code = 2'd0;        // R9: must not change the target
    on_dly_code = 2'd3;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      chk_state(0, 0, "R3 no lock no ramp");
    end
    up_phase(2, 0, 2 * USTEP + 4);
    chk(int'(stage_lvl), 3, "R9 captured target");
    down_phase(1, 3, "R9 ramp-down");
  endtask

  task automatic test_abort_delay;
    start_req(3, 2, 0);
    up_phase(3, 2, 20);
    burst_end = 1'b1;
    for (int t = 0; t < dly_cyc(2) + 20; t++) begin
      @(negedge clk);
      burst_end = 1'b0;
      chk_state(0, 0, "R8 abort in delay");
    end
    pll_lock = 1'b0;
  endtask

  task automatic test_abort_lockwait;
    start_req(1, 0, 0);
    burst_end = 1'b1;
    @(negedge clk);
    burst_end = 1'b0;
    pll_lock = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      chk_state(0, 0, "R8 abort in lock wait");
    end
    pll_lock = 1'b0;
  endtask

  task automatic test_abort_climb;
    start_req(3, 0, 1);
    up_phase(3, 0, USTEP + 1);
    chk(int'(stage_lvl), 2, "R8 level before abort");
    down_phase(1, 2, "R8 abort in climb");
  endtask

  initial begin
    test_reset();
    run_full(3, 1, 2);
    run_full(0, 0, 0);
    run_full(2, 3, 3);
    run_full(1, 2, 1);
    test_nonburst();
    test_nolock_capture();
    test_abort_delay();
    test_abort_lockwait();
    test_abort_climb();
    run_full(3, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule